// File: doc/BRIEF.md
# Timing-Error Capture and Replay Controller

This block gathers late-arrival error flags from a set of guarded pipeline endpoints. These endpoints include datapath flops, clock-gate enables, and the inputs of the instruction and data memories. Each endpoint owns a sticky history bit. The bit records that the endpoint has failed at least once, so a diagnostic read can later point at the failing flop. Software clears history bits only by writing ones to them. A separate saturating counter tallies the cycles in which any endpoint reported an error.

The OR of all flags travels through a chain of stabilization registers. This chain gives late signals time to settle and synchronizes the error before anything retires. While an error is anywhere in that chain, the block refuses to let the oldest instruction commit. When the error leaves the end of the chain, the block recovers in three steps:

- It issues a one-cycle flush.
- It captures the tag of the oldest uncommitted instruction as the restart point.
- It asks the clock generator for half-rate operation.

The half-rate request stays high until the restart instruction has committed.

Top module: `tec_replay_ctrl`

## Requirements
- R1: An error on endpoint i (bit i of `epErr`) sampled at a rising edge makes bit i of `histRdata` read 1 after that edge.
- R2: A history bit that is set stays set until a clear write (`histClrWe` high with bit i of `histClrMask` high). No other input clears it, including idle cycles and recovery.
- R3: When an error and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R4: `commitGrant` equals `commitReq`, except that it is 0 in three cases: any `epErr` bit is high in that cycle, an error sampled in one of the last `STAB_STAGES` edges has not yet left the stabilization chain, or the flush cycle is in progress.
- R5: A cycle with any error, sampled at edge E, makes `flush` high for exactly the one cycle that follows edge E+`STAB_STAGES`. No flush occurs without an error.
- R6: On the edge that starts the flush, `replayTag` loads the `commitTag` value of that cycle, which is the oldest uncommitted instruction. It holds that value until the next flush.
- R7: `halfRate` rises together with `flush`. It falls after the edge where a commit is granted with `commitTag` equal to `replayTag` while the flush cycle is not in progress.
- R8: No commit is granted in a cycle where `flush` is high.
- R9: `errCount` adds one for each cycle in which any endpoint flags an error, and stops at 2^`CNT_W`-1 without wrapping. When `cntClr` is high the count goes to 0, and this wins over an error in the same cycle.
- R10: An error confirmed during replay issues a new flush, reloads `replayTag` and keeps `halfRate` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| epErr | input | NUM_EP | Per-endpoint timing-error flags |
| commitReq | input | 1 | Pipeline asks to retire its oldest instruction |
| commitTag | input | TAG_W | Tag of the oldest uncommitted instruction |
| commitGrant | output | 1 | Retirement permitted this cycle |
| flush | output | 1 | One-cycle pipeline flush |
| replayTag | output | TAG_W | Restart point for the replay |
| halfRate | output | 1 | Request for half-rate clock |
| histClrWe | input | 1 | Write strobe for the history clear |
| histClrMask | input | NUM_EP | Ones select history bits to clear |
| histRdata | output | NUM_EP | Sticky per-endpoint failure history |
| cntClr | input | 1 | Zero the error counter |
| errCount | output | CNT_W | Saturating count of error cycles |

## Verification
The bound checker tests several properties on every cycle:

- No grant is issued while an endpoint flag is high or during a flush.
- History bits only rise unless a clear is written, and every reported error sets its own bit.
- The counter never falls without a clear and stays at its ceiling.
- `halfRate` covers every flush and drops only right after the restart instruction commits.

The exact `STAB_STAGES` latency from error to flush, and the restart tag chosen, are shown only by the bench's scenarios. The same holds for set-over-clear priority and a second failure during replay. The bench compares these against its cycle model under random traffic and directed corner cases.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_FLUSH  = 2'd1,
    ST_REPLAY = 2'd2
  } recState_t;

  // control -> datapath
  typedef struct packed {
    logic latchTag;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pending;
    logic confirm;
  } dpStatus_t;
endpackage

// File: rtl/tec_datapath.sv
module tec_datapath
  import tec_pkg::*;
#(
  parameter int NUM_EP      = 16,
  parameter int STAB_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int TAG_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EP-1:0] epErr,
  input  logic              histClrWe,
  input  logic [NUM_EP-1:0] histClrMask,
  input  logic              cntClr,
  input  logic [TAG_W-1:0]  commitTag,
  input  ctlStrobe_t        strobe,
  output dpStatus_t         status,
  output logic [NUM_EP-1:0] histQ,
  output logic [CNT_W-1:0]  errCount,
  output logic [TAG_W-1:0]  replayTag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                   errAny;
  logic [STAB_STAGES-1:0] stabQ;

  assign errAny = |epErr;

  // sticky history, one bit per endpoint; a new error beats a clear
  for (genvar g = 0; g < NUM_EP; g++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                histQ[g] <= 1'b0;
      else if (epErr[g])                        histQ[g] <= 1'b1;
      else if (histClrWe && histClrMask[g])     histQ[g] <= 1'b0;
    end
  end

  // stabilization chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stabQ[0] <= 1'b0;
    else       stabQ[0] <= errAny;
  end
  for (genvar s = 1; s < STAB_STAGES; s++) begin : g_stab
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stabQ[s] <= 1'b0;
      else       stabQ[s] <= stabQ[s-1];
    end
  end

  assign status.confirm = stabQ[STAB_STAGES-1];
  assign status.pending = errAny | (|stabQ);

  // saturating event counter, clear has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           errCount <= '0;
    else if (cntClr)                     errCount <= '0;
    else if (errAny && errCount != CNT_MAX) errCount <= errCount + 1'b1;
  end

  // restart point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               replayTag <= '0;
    else if (strobe.latchTag) replayTag <= commitTag;
  end
endmodule

// File: rtl/tec_control.sv
module tec_control
  import tec_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             commitReq,
  input  logic [TAG_W-1:0] commitTag,
  input  logic [TAG_W-1:0] replayTag,
  input  dpStatus_t        status,
  output ctlStrobe_t       strobe,
  output logic             commitGrant,
  output logic             flush,
  output logic             halfRate
);
  recState_t state, stateNxt;

  assign commitGrant = commitReq && !status.pending && (state != ST_FLUSH);
  assign flush       = (state == ST_FLUSH);
  assign halfRate    = (state != ST_RUN);

  always_comb begin
    stateNxt        = state;
    strobe.latchTag = 1'b0;
    if (status.confirm) begin
      stateNxt        = ST_FLUSH;
      strobe.latchTag = 1'b1;
    end else begin
      unique case (state)
        ST_FLUSH:  stateNxt = ST_REPLAY;
        ST_REPLAY: if (commitGrant && commitTag == replayTag) stateNxt = ST_RUN;
        default:   stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/tec_replay_ctrl.sv
module tec_replay_ctrl
  import tec_pkg::*;
#(
  parameter int NUM_EP      = 16,
  parameter int STAB_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int TAG_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EP-1:0] epErr,
  input  logic              commitReq,
  input  logic [TAG_W-1:0]  commitTag,
  output logic              commitGrant,
  output logic              flush,
  output logic [TAG_W-1:0]  replayTag,
  output logic              halfRate,
  input  logic              histClrWe,
  input  logic [NUM_EP-1:0] histClrMask,
  output logic [NUM_EP-1:0] histRdata,
  input  logic              cntClr,
  output logic [CNT_W-1:0]  errCount
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  tec_datapath #(
    .NUM_EP(NUM_EP), .STAB_STAGES(STAB_STAGES), .CNT_W(CNT_W), .TAG_W(TAG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .epErr(epErr), .histClrWe(histClrWe),
    .histClrMask(histClrMask), .cntClr(cntClr), .commitTag(commitTag),
    .strobe(strobe), .status(status), .histQ(histRdata),
    .errCount(errCount), .replayTag(replayTag)
  );

  tec_control #(.TAG_W(TAG_W)) u_ctl (
    .clk(clk), .rstN(rstN), .commitReq(commitReq), .commitTag(commitTag),
    .replayTag(replayTag), .status(status), .strobe(strobe),
    .commitGrant(commitGrant), .flush(flush), .halfRate(halfRate)
  );
endmodule

// File: rtl/tec_replay_ctrl_chk.sv
module tec_replay_ctrl_chk #(
  parameter int NUM_EP = 16,
  parameter int CNT_W  = 8,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_EP-1:0] epErr,
  input logic              commitReq,
  input logic [TAG_W-1:0]  commitTag,
  input logic              commitGrant,
  input logic              flush,
  input logic [TAG_W-1:0]  replayTag,
  input logic              halfRate,
  input logic              histClrWe,
  input logic [NUM_EP-1:0] histClrMask,
  input logic [NUM_EP-1:0] histRdata,
  input logic              cntClr,
  input logic [CNT_W-1:0]  errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_hist_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|epErr) |=> ((histRdata & $past(epErr)) == $past(epErr)));

  p_hist_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !histClrWe |=> ((histRdata & $past(histRdata)) == $past(histRdata)));

  p_no_grant_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitGrant |-> (epErr == '0));

  p_no_grant_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !commitGrant);

  p_half_cover_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> halfRate);

  p_half_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halfRate) |-> ($past(commitGrant) && $past(commitTag) == $past(replayTag)));

  p_cnt_mono_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cntClr |=> (errCount >= $past(errCount)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX && !cntClr) |=> (errCount == CNT_MAX));
endmodule

bind tec_replay_ctrl tec_replay_ctrl_chk #(
  .NUM_EP(NUM_EP), .CNT_W(CNT_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/tec_replay_ctrl_tb.sv
module tec_replay_ctrl_tb;
  localparam int NUM_EP = 16;
  localparam int STAB   = 2;
  localparam int CNT_W  = 8;
  localparam int TAG_W  = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_EP-1:0] epErr = '0;
  logic              commitReq = 1'b0;
  logic [TAG_W-1:0]  commitTag = '0;
  logic              commitGrant, flush, halfRate;
  logic [TAG_W-1:0]  replayTag;
  logic              histClrWe = 1'b0;
  logic [NUM_EP-1:0] histClrMask = '0;
  logic [NUM_EP-1:0] histRdata;
  logic              cntClr = 1'b0;
  logic [CNT_W-1:0]  errCount;

  always #4 clk = ~clk;

  tec_replay_ctrl #(.NUM_EP(NUM_EP), .STAB_STAGES(STAB), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .epErr(epErr), .commitReq(commitReq), .commitTag(commitTag),
    .commitGrant(commitGrant), .flush(flush), .replayTag(replayTag), .halfRate(halfRate),
    .histClrWe(histClrWe), .histClrMask(histClrMask), .histRdata(histRdata),
    .cntClr(cntClr), .errCount(errCount)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state: 0 run, 1 flush, 2 replay
  logic [NUM_EP-1:0] mHist = '0;
  logic [STAB-1:0]   mStab = '0;
  int                mCnt = 0;
  int                mState = 0;
  logic [TAG_W-1:0]  mTag = '0;
  logic [TAG_W-1:0]  curTag = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expGrant(input logic [NUM_EP-1:0] e, input bit req);
    return req && (e == '0) && (mStab == '0) && (mState != 1);
  endfunction

  // one clock: check registered outputs, drive, check grant, advance model
  task automatic cyc(input logic [NUM_EP-1:0] e, input bit req,
                     input bit clrWe, input logic [NUM_EP-1:0] mask, input bit cClr);
    bit g, conf;
    @(negedge clk);
    chk("R1/R2 history", 32'(histRdata), 32'(mHist));
    chk("R9 count", 32'(errCount), 32'(mCnt));
    chk("R5 flush", 32'(flush), 32'(mState == 1));
    chk("R7 halfRate", 32'(halfRate), 32'(mState != 0));
    if (mState != 0) chk("R6 replayTag", 32'(replayTag), 32'(mTag));
    epErr = e; commitReq = req; commitTag = curTag;
    histClrWe = clrWe; histClrMask = mask; cntClr = cClr;
    #1;
    g = expGrant(e, req);
    chk(mState == 1 ? "R8 grant in flush" : "R4 grant", 32'(commitGrant), 32'(g));
    @(posedge clk);
    conf  = mStab[STAB-1];
    mHist = (mHist & ~(clrWe ? mask : '0)) | e;
    if (cClr) mCnt = 0;
    else if (e != '0 && mCnt != CMAX) mCnt++;
    if (conf) begin mState = 1; mTag = curTag; end
    else if (mState == 1) mState = 2;
    else if (mState == 2 && g && curTag == mTag) mState = 0;
    mStab = {mStab[STAB-2:0], |e};
    if (g) curTag++;
  endtask

  task automatic idle(input int n, input bit req);
    for (int i = 0; i < n; i++) cyc('0, req, 1'b0, '0, 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int flushSeen;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state
    @(negedge clk);
    chk("R1 reset history", 32'(histRdata), 0);
    chk("R9 reset count", 32'(errCount), 0);
    chk("R7 reset halfRate", 32'(halfRate), 0);
    idle(3, 1'b1);

    // single failure on endpoint 3 with commit pressure
    cyc(16'h0008, 1'b1, 1'b0, '0, 1'b0);
    idle(1, 1'b1);
    // edge E0 was the error cycle; after edge E2 flush must show
    cyc('0, 1'b1, 1'b0, '0, 1'b0);
    #2 chk("R5 flush after stab stages", 32'(flush), 1);
    chk("R7 halfRate with flush", 32'(halfRate), 1);
    chk("R6 restart tag", 32'(replayTag), 32'(curTag));
    idle(4, 1'b1);
    chk("R7 full rate after replay commit", 32'(halfRate), 0);
    chk("R1 endpoint3 recorded", 32'(histRdata[3]), 1);

    // R2: history untouched by idle and clear of other bits
    idle(5, 1'b0);
    cyc('0, 1'b0, 1'b1, 16'hFFF7, 1'b0);
    #2 chk("R2 sticky under other clear", 32'(histRdata[3]), 1);
    cyc('0, 1'b0, 1'b1, 16'h0008, 1'b0);
    #2 chk("R2 W1C clears", 32'(histRdata[3]), 0);

    // R3: set and clear of bit 5 together
    cyc(16'h0020, 1'b0, 1'b1, 16'h0020, 1'b0);
    #2 chk("R3 set beats clear", 32'(histRdata[5]), 1);
    idle(6, 1'b1);

    // R10: second error during replay
    cyc(16'h0100, 1'b0, 1'b0, '0, 1'b0);
    idle(3, 1'b0);
    #2 chk("R10 in replay", 32'(halfRate && !flush), 1);
    cyc(16'h0001, 1'b0, 1'b0, '0, 1'b0);
    idle(2, 1'b0);
    #2 chk("R10 reflush", 32'(flush), 1);
    chk("R10 halfRate held", 32'(halfRate), 1);
    idle(4, 1'b1);

    // R9: saturation then clear priority
    for (int i = 0; i < CMAX + 20; i++) cyc(16'h8000, 1'b0, 1'b0, '0, 1'b0);
    #2 chk("R9 saturated", 32'(errCount), CMAX);
    cyc(16'h8000, 1'b0, 1'b0, '0, 1'b1);
    #2 chk("R9 clear wins", 32'(errCount), 0);
    idle(8, 1'b1);

    // random traffic
    flushSeen = 0;
    for (int i = 0; i < 4000; i++) begin
      logic [NUM_EP-1:0] e;
      e = ($urandom % 24 == 0) ? NUM_EP'($urandom) : '0;
      cyc(e, ($urandom % 10) < 7, ($urandom % 20) == 0, NUM_EP'($urandom), ($urandom % 50) == 0);
      if (flush) flushSeen++;
    end
    idle(10, 1'b1);
    chk("R5 random flushes seen", 32'(flushSeen > 0), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule